// File: doc/BRIEF.md
# Cascadable Eight-Line Interrupt Controller

The block collects interrupt requests from two banks of eight lines and hands the CPU one interrupt vector at a time. Each bank is served by its own controller. The primary controller takes the first bank. The secondary controller takes the second bank and reports through input 2 of the primary. Each controller has a command port and a data port on a shared register bus, and `busSel` chooses the controller.

Software configures a controller with a short initialization sequence. A command word with bit 4 set starts the sequence. Later data-port writes then load the vector base, then the cascade word, then a final option word. Whether the cascade word and the option word are expected depends on bits 1 and 0 of that first word. Outside initialization:
- a data write loads the interrupt mask;
- command writes issue end-of-interrupt (EOI) operations or arm a one-shot readback of the in-service register.

Request lines are edge-detected and held until delivered. The winning request is presented as `vecData` with `vecValid`, which stays up until `vecAck`.

Top module: `irq_ctrl_cascade`

## Requirements
- R1: After reset, `vecValid` is 0, a data-port read of either controller returns 8'hFF (all lines masked), and a command-port read returns 8'h00.
- R2: A command write with bit 4 set starts initialization; bit 1 set means single mode and bit 0 set means an option word follows. The next data write sets the vector base with its low three bits forced to 0. In single mode with no option word, initialization then ends, and the next data write loads the mask.
- R3: When bit 1 of the first word is clear (cascade mode), the data write after the vector base is taken as the cascade word. Initialization then ends unless bit 0 of the first word asked for an option word.
- R4: If bit 1 of the option word is set, that controller delivers interrupts without setting its in-service bits (automatic EOI).
- R5: Outside initialization, a data write loads the mask (bit n masks line n), and a data read returns the mask.
- R6: Command write 8'h0B makes the next command-port read of that controller return its in-service register, exactly once. Command reads otherwise return 8'h00.
- R7: A command write with bit 5 set and bits 4 and 3 clear is an EOI. With bit 6 set it clears only the in-service bit numbered by bits 2:0. With bit 6 clear it clears the whole in-service register.
- R8: A rising edge on an unmasked line is held pending until delivered. A rising edge on a masked line is discarded and is not delivered after a later unmask. Among deliverable primary lines the lowest number wins.
- R9: A pending line is not delivered while its own or any lower-numbered in-service bit of its controller is set. A higher-priority line is still delivered, and the held line is delivered once an EOI releases it.
- R10: A delivered vector equals the controller's vector base plus the line number. It stays stable with `vecValid` high until `vecAck`, falls the cycle after `vecAck`, and no new vector is issued while one is outstanding.
- R11: A secondary line is delivered only if all of the following hold: the primary cascade word has bit 2 set, the secondary cascade word equals 2, and the primary in-service register is 0. Delivery sets primary in-service bit 2 and the secondary line's bit.
- R12: When an EOI write and a delivery happen in the same cycle, the EOI clears its bits and the delivered line's bit is set.
- R13: A controller delivers nothing while its initialization sequence is in progress. Requests that arrive during that time are delivered once the sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Controller select: 0 primary, 1 secondary |
| busAddr | input | 1 | Port select: 0 command, 1 data |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe, one cycle per read |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the selected controller and port |
| priReq | input | 8 | Request lines of the primary controller |
| secReq | input | 8 | Request lines of the secondary controller |
| vecValid | output | 1 | Interrupt vector is presented |
| vecData | output | 8 | Interrupt vector |
| vecAck | input | 1 | CPU acknowledges the presented vector |

## Verification
Two things can meet in a single clock edge: an EOI register write and a delivery that sets a new in-service bit. The bench sets up this collision on purpose. First it leaves line 1 in service. It then raises line 0 on the falling edge before the EOI write starts, so the pending bit is captured one edge before the write. This makes the delivery land on the same edge as a specific EOI for line 1. The outcome is judged through the ports: the vector must read base plus 0, and the armed in-service readback must return exactly bit 0. That readback shows both that the EOI clear was not lost and that the new set was not overwritten.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LINES = 8;
  localparam int DW = LINES;
  localparam int LW = $clog2(LINES);
  localparam int CASC_LINE = 2;

  localparam int CMD_INIT_BIT = 4;
  localparam int CMD_OCW3_BIT = 3;
  localparam int CMD_EOI_BIT = 5;
  localparam int CMD_SPEC_BIT = 6;
  localparam int CFG_SINGLE_BIT = 1;
  localparam int CFG_WORD4_BIT = 0;
  localparam int WORD4_AEOI_BIT = 1;
  localparam logic [DW-1:0] READ_ISR_CMD = 8'h0B;

  typedef enum logic [1:0] {ST_IDLE, ST_BASE, ST_CASC, ST_WORD4} initSt_t;

  typedef struct packed {
    logic ldCfg;
    logic ldBase;
    logic ldCasc;
    logic ldWord4;
    logic ldMask;
    logic armIsrRd;
    logic dropIsrRd;
    logic eoiAll;
    logic eoiOne;
    logic [LW-1:0] eoiLine;
  } regStb_t;

  typedef struct packed {
    logic fire;
    logic fromSec;
    logic [LW-1:0] line;
  } dlvStb_t;
endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  regStb_t          stb,
  input  logic [DW-1:0]    wdata,
  input  logic [LINES-1:0] setIsr,
  output logic [LINES-1:0] mask,
  output logic [LINES-1:0] isr,
  output logic [DW-1:0]    base,
  output logic [DW-1:0]    casc,
  output logic             autoEoi,
  output logic             cfgSingle,
  output logic             cfgWord4,
  output logic [DW-1:0]    cmdRdata,
  output logic [DW-1:0]    dataRdata
);
  localparam logic [LINES-1:0] ONE = {{(LINES-1){1'b0}}, 1'b1};

  logic isrRdArm;
  logic [LINES-1:0] clrIsr;
  logic [LINES-1:0] isrNext;

  always_comb begin
    clrIsr = '0;
    if (stb.eoiAll) clrIsr = '1;
    else if (stb.eoiOne) clrIsr = ONE << stb.eoiLine;
    isrNext = (isr & ~clrIsr) | setIsr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mask      <= '1;
      isr       <= '0;
      base      <= '0;
      casc      <= '0;
      autoEoi   <= 1'b0;
      cfgSingle <= 1'b0;
      cfgWord4  <= 1'b0;
      isrRdArm  <= 1'b0;
    end else begin
      if (stb.ldCfg) begin
        cfgSingle <= wdata[CFG_SINGLE_BIT];
        cfgWord4  <= wdata[CFG_WORD4_BIT];
        casc      <= '0;
        autoEoi   <= 1'b0;
      end
      if (stb.ldBase) base <= {wdata[DW-1:LW], {LW{1'b0}}};
      if (stb.ldCasc) casc <= wdata;
      if (stb.ldWord4) autoEoi <= wdata[WORD4_AEOI_BIT];
      if (stb.ldMask) mask <= wdata;
      if (stb.armIsrRd) isrRdArm <= 1'b1;
      else if (stb.dropIsrRd) isrRdArm <= 1'b0;
      isr <= isrNext;
    end
  end

  assign cmdRdata  = isrRdArm ? isr : '0;
  assign dataRdata = mask;
endmodule

// File: rtl/pic_vec.sv
module pic_vec
  import pic_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0][LINES-1:0] req,
  input  logic [1:0][LINES-1:0] mask,
  input  logic [1:0][DW-1:0]    base,
  input  dlvStb_t               dlv,
  input  logic                  vecAck,
  output logic [1:0][LINES-1:0] pend,
  output logic                  vecValid,
  output logic [DW-1:0]         vecData
);
  localparam logic [LINES-1:0] ONE = {{(LINES-1){1'b0}}, 1'b1};

  logic [1:0][LINES-1:0] prev;

  for (genvar c = 0; c < 2; c++) begin : g_bank
    logic [LINES-1:0] svc;
    logic [LINES-1:0] rise;
    assign svc  = (dlv.fire && (dlv.fromSec == c[0])) ? (ONE << dlv.line) : '0;
    assign rise = req[c] & ~prev[c] & ~mask[c];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prev[c] <= '0;
        pend[c] <= '0;
      end else begin
        prev[c] <= req[c];
        pend[c] <= (pend[c] & ~svc) | rise;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecValid <= 1'b0;
      vecData  <= '0;
    end else if (dlv.fire) begin
      vecValid <= 1'b1;
      vecData  <= base[dlv.fromSec] | DW'(dlv.line);
    end else if (vecAck) begin
      vecValid <= 1'b0;
    end
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busAddr,
  input  logic                  busWr,
  input  logic                  busRd,
  input  logic [DW-1:0]         busWdata,
  input  logic [1:0]            cfgSingle,
  input  logic [1:0]            cfgWord4,
  input  logic [1:0][LINES-1:0] mask,
  input  logic [1:0][LINES-1:0] isr,
  input  logic [1:0][LINES-1:0] pend,
  input  logic [1:0][DW-1:0]    casc,
  input  logic                  vecValid,
  output regStb_t [1:0]         regStb,
  output dlvStb_t               dlv,
  output logic [1:0]            idle
);
  localparam logic [DW-1:0] CASC_BIT = DW'(1) << CASC_LINE;

  for (genvar c = 0; c < 2; c++) begin : g_fsm
    initSt_t st, stNext;
    regStb_t stb;
    logic wrCmd, wrData, rdCmd;

    assign wrCmd  = busWr && (busSel == c[0]) && !busAddr;
    assign wrData = busWr && (busSel == c[0]) && busAddr;
    assign rdCmd  = busRd && !busWr && (busSel == c[0]) && !busAddr;

    always_comb begin
      stb = '0;
      stNext = st;
      if (wrCmd) begin
        if (busWdata[CMD_INIT_BIT]) begin
          stb.ldCfg = 1'b1;
          stNext = ST_BASE;
        end else if (busWdata[CMD_OCW3_BIT]) begin
          stb.armIsrRd = (busWdata == READ_ISR_CMD);
        end else if (busWdata[CMD_EOI_BIT]) begin
          stb.eoiAll  = !busWdata[CMD_SPEC_BIT];
          stb.eoiOne  = busWdata[CMD_SPEC_BIT];
          stb.eoiLine = busWdata[LW-1:0];
        end
      end
      if (rdCmd) stb.dropIsrRd = 1'b1;
      if (wrData) begin
        case (st)
          ST_IDLE: stb.ldMask = 1'b1;
          ST_BASE: begin
            stb.ldBase = 1'b1;
            if (!cfgSingle[c]) stNext = ST_CASC;
            else if (cfgWord4[c]) stNext = ST_WORD4;
            else stNext = ST_IDLE;
          end
          ST_CASC: begin
            stb.ldCasc = 1'b1;
            stNext = cfgWord4[c] ? ST_WORD4 : ST_IDLE;
          end
          default: begin
            stb.ldWord4 = 1'b1;
            stNext = ST_IDLE;
          end
        endcase
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) st <= ST_IDLE;
      else st <= stNext;
    end

    assign regStb[c] = stb;
    assign idle[c]   = (st == ST_IDLE);
  end

  logic cascOk, secOpen;
  logic [LINES-1:0] priElig, secElig;

  assign cascOk  = ((casc[0] & CASC_BIT) != '0) && (casc[1] == DW'(CASC_LINE));
  assign secOpen = cascOk && idle[0] && idle[1] && (isr[0] == '0);

  for (genvar n = 0; n < LINES; n++) begin : g_elig
    localparam logic [LINES-1:0] UPTO = LINES'((64'd1 << (n + 1)) - 64'd1);
    assign priElig[n] = pend[0][n] && !mask[0][n] && ((isr[0] & UPTO) == '0) && idle[0];
    assign secElig[n] = pend[1][n] && !mask[1][n] && ((isr[1] & UPTO) == '0) && secOpen;
  end

  always_comb begin
    dlvStb_t pick;
    pick = '0;
    for (int n = LINES - 1; n > CASC_LINE; n--) begin
      if (priElig[n]) begin
        pick.fire = 1'b1; pick.fromSec = 1'b0; pick.line = LW'(n);
      end
    end
    for (int n = LINES - 1; n >= 0; n--) begin
      if (secElig[n]) begin
        pick.fire = 1'b1; pick.fromSec = 1'b1; pick.line = LW'(n);
      end
    end
    for (int n = CASC_LINE; n >= 0; n--) begin
      if (priElig[n]) begin
        pick.fire = 1'b1; pick.fromSec = 1'b0; pick.line = LW'(n);
      end
    end
    if (vecValid) pick.fire = 1'b0;
    dlv = pick;
  end
endmodule

// File: rtl/irq_ctrl_cascade.sv
module irq_ctrl_cascade
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busAddr,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [DW-1:0]    busWdata,
  output logic [DW-1:0]    busRdata,
  input  logic [LINES-1:0] priReq,
  input  logic [LINES-1:0] secReq,
  output logic             vecValid,
  output logic [DW-1:0]    vecData,
  input  logic             vecAck
);
  localparam logic [LINES-1:0] ONE = {{(LINES-1){1'b0}}, 1'b1};

  regStb_t [1:0] regStb;
  dlvStb_t dlv;
  logic [1:0] idle, autoEoi, cfgSingle, cfgWord4;
  logic [1:0][LINES-1:0] mask, isr, pend, setIsr, req;
  logic [1:0][DW-1:0] base, casc, cmdRd, dataRd;

  logic [LINES-1:0] priIsr, priMask;
  logic priIdle, dlvFire, dlvFromSec;

  assign req[0] = priReq;
  assign req[1] = secReq;

  pic_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .busWdata(busWdata),
    .cfgSingle(cfgSingle), .cfgWord4(cfgWord4), .mask(mask), .isr(isr),
    .pend(pend), .casc(casc), .vecValid(vecValid),
    .regStb(regStb), .dlv(dlv), .idle(idle)
  );

  always_comb begin
    setIsr = '0;
    if (dlv.fire) begin
      if (dlv.fromSec) begin
        if (!autoEoi[0]) setIsr[0][CASC_LINE] = 1'b1;
        if (!autoEoi[1]) setIsr[1] = ONE << dlv.line;
      end else if (!autoEoi[0]) begin
        setIsr[0] = ONE << dlv.line;
      end
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_regs
    pic_regs u_regs (
      .clk(clk), .rstN(rstN), .stb(regStb[c]), .wdata(busWdata),
      .setIsr(setIsr[c]), .mask(mask[c]), .isr(isr[c]), .base(base[c]),
      .casc(casc[c]), .autoEoi(autoEoi[c]), .cfgSingle(cfgSingle[c]),
      .cfgWord4(cfgWord4[c]), .cmdRdata(cmdRd[c]), .dataRdata(dataRd[c])
    );
  end

  pic_vec u_vec (
    .clk(clk), .rstN(rstN), .req(req), .mask(mask), .base(base),
    .dlv(dlv), .vecAck(vecAck), .pend(pend),
    .vecValid(vecValid), .vecData(vecData)
  );

  assign busRdata   = busAddr ? dataRd[busSel] : cmdRd[busSel];
  assign priIsr     = isr[0];
  assign priMask    = mask[0];
  assign priIdle    = idle[0];
  assign dlvFire    = dlv.fire;
  assign dlvFromSec = dlv.fromSec;
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
  parameter int LINES = 8,
  parameter int DW = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             busSel,
  input logic             busAddr,
  input logic             busWr,
  input logic [DW-1:0]    busWdata,
  input logic             vecValid,
  input logic [DW-1:0]    vecData,
  input logic             vecAck,
  input logic [LINES-1:0] priIsr,
  input logic [LINES-1:0] priMask,
  input logic             priIdle,
  input logic             dlvFire,
  input logic             dlvFromSec
);
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    vecValid && vecAck |=> !vecValid); // R10
  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rstN)
    vecValid && !vecAck |=> vecValid && $stable(vecData)); // R10
  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rstN)
    dlvFire |-> !vecValid); // R10
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    busWr && !busSel && busAddr && priIdle |=> priMask == $past(busWdata)); // R5
  AST_EOI_ALL: assert property (@(posedge clk) disable iff (!rstN)
    busWr && !busSel && !busAddr && busWdata == 8'h20 && !dlvFire |=> priIsr == '0); // R7
  AST_SEC_GATE: assert property (@(posedge clk) disable iff (!rstN)
    dlvFire && dlvFromSec |-> priIsr == '0); // R11
endmodule

bind irq_ctrl_cascade irq_ctrl_checker #(.LINES(8), .DW(8)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busAddr(busAddr), .busWr(busWr),
  .busWdata(busWdata), .vecValid(vecValid), .vecData(vecData), .vecAck(vecAck),
  .priIsr(priIsr), .priMask(priMask), .priIdle(priIdle),
  .dlvFire(dlvFire), .dlvFromSec(dlvFromSec)
);

// File: tb/tb_irq_ctrl_cascade.sv
module tb_irq_ctrl_cascade;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busAddr = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic [7:0] priReq = 8'h00, secReq = 8'h00;
  logic vecValid;
  logic [7:0] vecData;
  logic vecAck = 1'b0;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  irq_ctrl_cascade dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata),
    .priReq(priReq), .secReq(secReq), .vecValid(vecValid),
    .vecData(vecData), .vecAck(vecAck)
  );

  typedef struct packed {
    logic       rd;
    logic       sel;
    logic       addr;
    logic [7:0] val;
    logic [3:0] req;
  } step_t;

  localparam int NSTEP = 14;
  localparam step_t STEPS [0:NSTEP-1] = '{
    '{1'b1, 1'b0, 1'b0, 8'h00, 4'd1},  // R1 command read is zero
    '{1'b1, 1'b0, 1'b1, 8'hFF, 4'd1},  // R1 mask all set
    '{1'b0, 1'b0, 1'b0, 8'h11, 4'd3},  // R3 primary: cascade, option word
    '{1'b0, 1'b0, 1'b1, 8'h47, 4'd2},  // R2 base 0x40 after forcing
    '{1'b0, 1'b0, 1'b1, 8'h04, 4'd3},  // R3 cascade word
    '{1'b0, 1'b0, 1'b1, 8'h01, 4'd4},  // R4 option word, no auto EOI
    '{1'b0, 1'b0, 1'b1, 8'h00, 4'd5},  // R5 mask open
    '{1'b1, 1'b0, 1'b1, 8'h00, 4'd5},  // R5 mask readback
    '{1'b0, 1'b1, 1'b0, 8'h11, 4'd3},  // R3 secondary init
    '{1'b0, 1'b1, 1'b1, 8'h73, 4'd2},  // R2 base 0x70
    '{1'b0, 1'b1, 1'b1, 8'h02, 4'd11}, // R11 cascade id 2
    '{1'b0, 1'b1, 1'b1, 8'h03, 4'd4},  // R4 auto EOI on
    '{1'b0, 1'b1, 1'b1, 8'hF0, 4'd5},  // R5 mask lines 4..7
    '{1'b1, 1'b1, 1'b1, 8'hF0, 4'd5}   // R5 mask readback
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkVec(input string req, input logic expValid, input logic [7:0] expData);
    check(req, {7'd0, vecValid}, {7'd0, expValid});
    if (expValid) check(req, vecData, expData);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic s, input logic a, input logic [7:0] d);
    @(negedge clk);
    busSel = s; busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic s, input logic a, output logic [7:0] d);
    @(negedge clk);
    busSel = s; busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic ackVec();
    @(negedge clk);
    vecAck = 1'b1;
    @(negedge clk);
    vecAck = 1'b0;
  endtask

  task automatic readIsr(input logic s, input string req, input logic [7:0] exp);
    logic [7:0] d;
    busWrite(s, 1'b0, 8'h0B);
    busRead(s, 1'b0, d);
    check(req, d, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    checkVec("R1", 1'b0, 8'h00);

    for (int i = 0; i < NSTEP; i++) begin
      if (STEPS[i].rd) begin
        busRead(STEPS[i].sel, STEPS[i].addr, d);
        check($sformatf("R%0d step %0d", STEPS[i].req, i), d, STEPS[i].val);
      end else begin
        busWrite(STEPS[i].sel, STEPS[i].addr, STEPS[i].val);
      end
    end

    // R8 lowest line wins, R10 vector held until ack
    @(negedge clk); priReq[3] = 1'b1; priReq[5] = 1'b1;
    tick(2);
    checkVec("R8", 1'b1, 8'h43);
    tick(3);
    checkVec("R10", 1'b1, 8'h43);
    readIsr(1'b0, "R6", 8'h08);
    busRead(1'b0, 1'b0, d);
    check("R6 one-shot", d, 8'h00);
    ackVec();
    checkVec("R10 after ack", 1'b0, 8'h00);
    tick(3);
    checkVec("R9 blocked", 1'b0, 8'h00);
    busWrite(1'b0, 1'b0, 8'h63);
    tick(1);
    checkVec("R9 released", 1'b1, 8'h45);
    ackVec();
    priReq[3] = 1'b0; priReq[5] = 1'b0;

    // R9 higher priority passes; R7 specific and full EOI
    @(negedge clk); priReq[1] = 1'b1;
    tick(2);
    checkVec("R9 higher", 1'b1, 8'h41);
    ackVec();
    readIsr(1'b0, "R6", 8'h22);
    busWrite(1'b0, 1'b0, 8'h65);
    readIsr(1'b0, "R7 specific", 8'h02);
    busWrite(1'b0, 1'b0, 8'h20);
    readIsr(1'b0, "R7 all", 8'h00);
    priReq[1] = 1'b0;

    // R8 masked edge discarded
    busWrite(1'b0, 1'b1, 8'h80);
    @(negedge clk); priReq[7] = 1'b1;
    tick(4);
    checkVec("R8 masked", 1'b0, 8'h00);
    busWrite(1'b0, 1'b1, 8'h00);
    tick(4);
    checkVec("R8 unmask no replay", 1'b0, 8'h00);
    priReq[7] = 1'b0;

    // R11 secondary path, R4 auto EOI on secondary
    @(negedge clk); secReq[1] = 1'b1;
    tick(2);
    checkVec("R11", 1'b1, 8'h71);
    readIsr(1'b0, "R11 primary bit2", 8'h04);
    readIsr(1'b1, "R4 auto EOI", 8'h00);
    ackVec();
    @(negedge clk); secReq[0] = 1'b1;
    tick(4);
    checkVec("R11 gated", 1'b0, 8'h00);
    busWrite(1'b0, 1'b0, 8'h20);
    tick(1);
    checkVec("R11 released", 1'b1, 8'h70);
    ackVec();
    busWrite(1'b0, 1'b0, 8'h20);
    secReq = 8'h00;

    // R12 EOI and delivery on the same edge
    @(negedge clk); priReq[1] = 1'b1;
    tick(2);
    checkVec("R12 setup", 1'b1, 8'h41);
    ackVec();
    @(negedge clk); priReq[0] = 1'b1;
    busWrite(1'b0, 1'b0, 8'h61);
    checkVec("R12", 1'b1, 8'h40);
    readIsr(1'b0, "R12 isr", 8'h01);
    ackVec();
    busWrite(1'b0, 1'b0, 8'h20);
    priReq = 8'h00;

    // R13 no delivery during initialization
    busWrite(1'b0, 1'b0, 8'h13);
    @(negedge clk); priReq[3] = 1'b1;
    tick(4);
    checkVec("R13 during init", 1'b0, 8'h00);
    busWrite(1'b0, 1'b1, 8'h48);
    busWrite(1'b0, 1'b1, 8'h00);
    tick(1);
    checkVec("R13 after init", 1'b1, 8'h4B);
    ackVec();
    busWrite(1'b0, 1'b0, 8'h20);
    priReq = 8'h00;

    // R3 cascade without option word
    busWrite(1'b1, 1'b0, 8'h10);
    busWrite(1'b1, 1'b1, 8'h58);
    busWrite(1'b1, 1'b1, 8'h02);
    busWrite(1'b1, 1'b1, 8'h0F);
    busRead(1'b1, 1'b1, d);
    check("R3", d, 8'h0F);

    // R2 single mode without option word
    busWrite(1'b1, 1'b0, 8'h12);
    busWrite(1'b1, 1'b1, 8'h60);
    busWrite(1'b1, 1'b1, 8'h33);
    busRead(1'b1, 1'b1, d);
    check("R2", d, 8'h33);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule